// File: doc/BRIEF.md
# Sampled Falling-Edge Phase-Frequency Detector

This block compares a reference pulse train against the divided feedback pulse train of a frequency synthesizer loop and produces pump requests for a differential charge pump. It reacts only to falling edges. When the reference edge leads, it raises a request to speed the oscillator up. When the feedback edge leads, it raises a request to slow it down. It stays idle otherwise. Each request is driven as a true and an inverted line, so that both halves of a differential pump get a clean pair.

The detector is modelled on a fast sampling clock. Both inputs pass through a synchronizer, and a falling edge is a sampled high-to-low step. Once both requests are active, a clear timer keeps them both high for a programmable number of sampling cycles before it clears them together. The guaranteed overlap removes the dead zone around zero phase error. A lead of P cycles therefore gives a leading pulse of P plus the delay and a trailing pulse of the delay alone.

A second falling edge on an input whose request is already set is absorbed. As a result, a frequency difference holds the request of the faster input high, and the block acts as a frequency detector as well as a phase detector.

Top module: `pfd_fall3`

## Requirements
- R1: After reset, `up` and `dn` are 0, and `up_n` and `dn_n` are 1.
- R2: Rising edges and steady levels on `ref_in` and `fb_in` produce no request; with both inputs held high after a rise, all four outputs keep their idle values.
- R3: When the `ref_in` falling edge leads the `fb_in` falling edge by P sampling cycles, `up` is high for P+D consecutive cycles and `dn` for D cycles, and `up` rises first. D is the effective clear delay.
- R4: When the `fb_in` falling edge leads by P cycles, `dn` is high for P+D cycles and `up` for D cycles, and `dn` rises first.
- R5: The effective delay D equals `dly_cfg` read as an unsigned number. `up` and `dn` are both high for exactly D consecutive cycles, and both return to 0 in the same cycle.
- R6: Falling edges on both inputs in the same sampling cycle make `up` and `dn` rise together, and each is high for exactly D cycles.
- R7: A further falling edge on an input whose request is already high changes nothing. That request stays high without a break until the other input's falling edge arrives and the clear delay has run.
- R8: `up_n` is always the inverse of `up`, and `dn_n` is always the inverse of `dn`.
- R9: A `dly_cfg` value of 0 acts as a delay of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_in | input | 1 | Reference pulse train (asynchronous) |
| fb_in | input | 1 | Divided feedback pulse train (asynchronous) |
| dly_cfg | input | DLY_W | Clear delay in sampling cycles (0 acts as 1) |
| up | output | 1 | Raise-frequency request, true |
| up_n | output | 1 | Raise-frequency request, inverted |
| dn | output | 1 | Lower-frequency request, true |
| dn_n | output | 1 | Lower-frequency request, inverted |

## Verification
The overlap bound assumes that `dly_cfg` does not change while both requests are high. The clear-together property assumes that no new falling edge lands in the exact cycle in which the timer clears. The stimulus writes `dly_cfg` only during an idle gap before each case. It spaces repeated reference edges far enough apart that they all fall before the feedback edge, and it holds both inputs low well beyond the longest expected pulse. Every phase lead from -5 to +5 cycles is swept against every delay setting from 0 to 4, with a maximal setting and a multi-edge frequency case added.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Lane indices for the two compared inputs
  localparam int unsigned LANE_REF = 0;
  localparam int unsigned LANE_FB  = 1;
  localparam int unsigned N_LANES  = 2;

  // Pending pump requests
  typedef struct packed {
    logic up;
    logic dn;
  } pump_req_t;

endpackage

// File: rtl/pfd_rst_sync.sv
module pfd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/pfd_fall_det.sv
module pfd_fall_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);

  logic cur;
  logic prev_q;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign cur = din;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      logic [SYNC_STAGES-1:0] sync_d;
      if (SYNC_STAGES == 1) begin : g_s1
        always_comb sync_d = din;
      end else begin : g_sn
        always_comb sync_d = {sync_q[SYNC_STAGES-2:0], din};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
      end
      assign cur = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  assign fall = prev_q & ~cur;

endmodule

// File: rtl/pfd_clr_timer.sv
module pfd_clr_timer #(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             both,
  input  logic [DLY_W-1:0] cfg,
  output logic             clr
);

  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] cnt_d;
  logic [DLY_W-1:0] last_idx;
  logic             cnt_en;

  // Zero is taken as a one-cycle delay
  always_comb begin
    if (cfg == '0) last_idx = '0;
    else           last_idx = cfg - 1'b1;
  end

  always_comb begin
    clr    = both && (cnt_q == last_idx);
    cnt_en = both || (cnt_q != '0);
    if (!both || clr) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pfd_drive.sv
module pfd_drive
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fall_ref,
  input  logic fall_fb,
  input  logic clr,
  output logic up,
  output logic up_n,
  output logic dn,
  output logic dn_n,
  output logic both
);

  pump_req_t req_q;
  pump_req_t req_d;
  logic      up_n_q;
  logic      dn_n_q;
  logic      upd_en;

  // Clear first, then a fresh edge sets again; an already-set flag absorbs edges
  always_comb begin
    req_d = req_q;
    if (clr)      req_d = '0;
    if (fall_ref) req_d.up = 1'b1;
    if (fall_fb)  req_d.dn = 1'b1;
    upd_en = clr | fall_ref | fall_fb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      up_n_q <= 1'b1;
      dn_n_q <= 1'b1;
    end else if (upd_en) begin
      req_q  <= req_d;
      up_n_q <= ~req_d.up;
      dn_n_q <= ~req_d.dn;
    end
  end

  assign up   = req_q.up;
  assign dn   = req_q.dn;
  assign up_n = up_n_q;
  assign dn_n = dn_n_q;
  assign both = req_q.up & req_q.dn;

endmodule

// File: rtl/pfd_fall3.sv
module pfd_fall3
  import pfd_pkg::*;
#(
  parameter int unsigned DLY_W       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic [DLY_W-1:0] dly_cfg,
  output logic             up,
  output logic             up_n,
  output logic             dn,
  output logic             dn_n
);

  logic               rst_n;
  logic [N_LANES-1:0] lane_in;
  logic [N_LANES-1:0] lane_fall;
  logic               both;
  logic               clr;

  assign lane_in[LANE_REF] = ref_in;
  assign lane_in[LANE_FB]  = fb_in;

  pfd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  generate
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      pfd_fall_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (lane_in[g]),
        .fall  (lane_fall[g])
      );
    end
  endgenerate

  pfd_clr_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .both  (both),
    .cfg   (dly_cfg),
    .clr   (clr)
  );

  pfd_drive u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_ref (lane_fall[LANE_REF]),
    .fall_fb  (lane_fall[LANE_FB]),
    .clr      (clr),
    .up       (up),
    .up_n     (up_n),
    .dn       (dn),
    .dn_n     (dn_n),
    .both     (both)
  );

endmodule

// File: rtl/pfd_fall3_chk.sv
module pfd_fall3_chk #(
  parameter int unsigned DLY_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DLY_W-1:0] dly_cfg,
  input logic             up,
  input logic             up_n,
  input logic             dn,
  input logic             dn_n
);

  logic [DLY_W:0] run_q;
  logic [DLY_W:0] lim;

  always_comb begin
    if (dly_cfg == '0) lim = 1;
    else               lim = {1'b0, dly_cfg};
  end

  // Count cycles of overlap already seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (up && dn) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  p_pair_up_r8: assert property (@(posedge clk) disable iff (!rst_n) up_n == !up);
  p_pair_dn_r8: assert property (@(posedge clk) disable iff (!rst_n) dn_n == !dn);
  p_both_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up && dn) |-> (run_q < lim));
  p_up_fall_from_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up) |-> $past(dn));
  p_dn_fall_from_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dn) |-> $past(up));
  p_up_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !dn) |=> up);
  p_dn_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn && !up) |=> dn);

endmodule

bind pfd_fall3 pfd_fall3_chk #(.DLY_W(DLY_W)) u_chk (
  .clk     (clk),
  .rst_n   (arst_n),
  .dly_cfg (dly_cfg),
  .up      (up),
  .up_n    (up_n),
  .dn      (dn),
  .dn_n    (dn_n)
);

// File: tb/sim_pfd_fall3.sv
module sim_pfd_fall3;

  localparam int DLY_W = 4;

  logic             clk = 1'b0;
  logic             arst_n = 1'b0;
  logic             ref_in = 1'b0;
  logic             fb_in = 1'b0;
  logic [DLY_W-1:0] dly_cfg = '0;
  logic             up, up_n, dn, dn_n;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  pfd_fall3 #(.DLY_W(DLY_W)) u0 (
    .clk(clk), .arst_n(arst_n), .ref_in(ref_in), .fb_in(fb_in),
    .dly_cfg(dly_cfg), .up(up), .up_n(up_n), .dn(dn), .dn_n(dn_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ref falls at ref_t (n_ref edges, 8 cycles apart), fb falls once at fb_t
  task automatic run_case(input int ref_t, input int fb_t, input int n_ref,
                          input int cfgv, input string req);
    int d, lead, exp_up, exp_dn;
    int up_w, dn_w, both_w, up_r, dn_r, up_first, dn_first, up_last, dn_last;
    int pair_bad, len;
    bit up_p, dn_p;
    d = (cfgv == 0) ? 1 : cfgv;
    dly_cfg = cfgv[DLY_W-1:0];
    ref_in = 1'b1;
    fb_in  = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    // R2: rises and steady highs give no request
    check(!up && !dn && up_n && dn_n, "R2", {up, dn}, 0);
    up_w = 0; dn_w = 0; both_w = 0; up_r = 0; dn_r = 0;
    up_first = -1; dn_first = -1; up_last = -1; dn_last = -1;
    pair_bad = 0; up_p = 1'b0; dn_p = 1'b0;
    len = ((ref_t > fb_t) ? ref_t : fb_t) + 8 * n_ref + 50;
    for (int i = 0; i < len; i++) begin
      @(posedge clk);
      #1;
      for (int k = 0; k < n_ref; k++) begin
        if (i == ref_t + 8 * k) ref_in = 1'b0;
        if (n_ref > 1 && i == ref_t + 8 * k + 4) ref_in = 1'b1;
      end
      if (n_ref == 1 && i == ref_t + 35) ref_in = 1'b1;
      if (i == fb_t) fb_in = 1'b0;
      if (i == fb_t + 35) fb_in = 1'b1;
      @(negedge clk);
      if (up_n != !up || dn_n != !dn) pair_bad++;
      if (up) begin up_w++; up_last = i; end
      if (dn) begin dn_w++; dn_last = i; end
      if (up && dn) both_w++;
      if (up && !up_p) begin up_r++; if (up_first < 0) up_first = i; end
      if (dn && !dn_p) begin dn_r++; if (dn_first < 0) dn_first = i; end
      up_p = up; dn_p = dn;
    end
    lead = fb_t - ref_t;
    exp_up = (lead > 0) ? lead + d : d;
    exp_dn = (lead < 0) ? -lead + d : d;
    check(up_w == exp_up, req, up_w, exp_up);
    check(dn_w == exp_dn, req, dn_w, exp_dn);
    check(up_r == 1 && dn_r == 1, req, up_r * 10 + dn_r, 11);
    if (lead > 0)      check(up_first < dn_first, req, up_first, dn_first - 1);
    else if (lead < 0) check(dn_first < up_first, req, dn_first, up_first - 1);
    else               check(up_first == dn_first, "R6", up_first, dn_first);
    check(both_w == d, "R5", both_w, d);
    check(up_last == dn_last, "R5", up_last, dn_last);
    check(pair_bad == 0, "R8", pair_bad, 0);
  endtask

  initial begin
    arst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: idle values while held in reset
    check(!up && !dn && up_n && dn_n, "R1", {up, dn, up_n, dn_n}, 4'b0011);
    arst_n = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(!up && !dn && up_n && dn_n, "R1", {up, dn, up_n, dn_n}, 4'b0011);

    for (int c = 0; c <= 4; c++) begin
      for (int p = -5; p <= 5; p++) begin
        string tag;
        if (c == 0)     tag = "R9";
        else if (p > 0) tag = "R3";
        else if (p < 0) tag = "R4";
        else            tag = "R6";
        run_case(10, 10 + p, 1, c, tag);
      end
    end
    run_case(10, 17, 1, 15, "R3");
    run_case(10, 4, 1, 15, "R4");
    // R7: extra reference edges while up is held
    run_case(5, 35, 4, 2, "R7");
    run_case(5, 40, 4, 1, "R7");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule